// File: doc/BRIEF.md
# Multi-Channel Temperature Sensor Sequencer

This block controls measurements for a temperature sensing unit. The unit has one internal probe and up to sixteen external probes. Software programs two control words through a small register port. The block then drives the probe multiplexer and issues sample strobes at a programmable rate. It averages the returned 10-bit raw codes over a power-of-two count and publishes the mean in a status word together with a valid flag.

A measurement starts after a settling wait, counted in clock cycles, during which no sample is taken and valid stays low. The block opens this wait in two cases: when measurement begins, and when the selected probe changes while measurement runs. Stopping or resetting the measurement drops valid at once and discards any partial average. The analog front end sits outside the block. Each raw code is presented on `raw_code` and is taken on the clock edge that ends a strobe cycle.

Top module: `thermo_sensor_ctrl`

## Requirements
- R1: After reset, both control words and the status word read as zero, `smp_strobe` is low and `mux_sel` is zero.
- R2: The register port decodes address 0 as control word A and address 1 as control word B. Both are read/write. Address 2 is the status word, which is read-only, so writes to it have no effect. Reads are combinational on `rd_data`.
- R3: Measurement runs only while control A bit 0 (start) and bit 2 (enable) are both 1 and bit 1 (reset) is 0. In any other combination no strobe is issued.
- R4: Control A bits 31:30 set the mode. The value 2 selects an external probe, and `mux_sel` then equals control A bits 16:13 plus one. Any other value selects the internal probe: `mux_sel` is 0 and bits 16:13 are ignored.
- R5: When measurement begins, no strobe occurs for SETTLE_CYC cycles. The first strobe is high in the cycle that follows SETTLE_CYC plus one sample period of clock edges after the write edge.
- R6: If the selected probe changes while measurement runs, valid drops within one cycle and the full settling wait restarts.
- R7: The sample period is SAMPLE_BASE shifted left by control A bits 25:24, in cycles.
- R8: Each result is the floor of the mean of 2^k consecutive samples, where k is control B bits 2:0. When control A bit 6 (bypass) is 1, every single sample is a result.
- R9: The status word holds the result in bits 9:0 and valid in bit 16. For n samples per result, valid first rises SETTLE_CYC + n·period + 1 clock edges after the edge that starts or changes the measurement.
- R10: Clearing start or setting reset drops valid on the next edge and flushes the partial average, so a later restart averages only fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| raw_code | input | CODE_W | Raw code from the selected probe |
| smp_strobe | output | 1 | Sample request; code taken at the edge ending this cycle |
| mux_sel | output | 5 | Probe select: 0 internal, N external index N-1 |

## Verification
The bench builds the block with SETTLE_CYC set to 20 and SAMPLE_BASE set to 3. With these values the exact valid latency can be counted to the cycle for every oversampling setting, including the slowest setting with eight-sample averaging, which completes in 213 cycles. The short windows also leave room to stop a measurement part-way through an average and to switch probes while measurement runs. In each case the bench compares the latency and the mean against values computed from a stub that supplies a known code sequence for each probe.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    localparam int CTL_W     = 32;
    localparam int BIT_START = 0;
    localparam int BIT_RST   = 1;
    localparam int BIT_EN    = 2;
    localparam int BIT_BYP   = 6;
    localparam int CH_LSB    = 13;
    localparam int CH_W      = 4;
    localparam int OSR_LSB   = 24;
    localparam int OSR_W     = 2;
    localparam int MODE_LSB  = 30;
    localparam logic [1:0] MODE_EXT = 2'd2;
    localparam int AVG_W     = 3;
    localparam int VALID_BIT = 16;
    localparam int SEL_W     = CH_W + 1;

    localparam logic [1:0] ADDR_CTLA = 2'd0;
    localparam logic [1:0] ADDR_CTLB = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_SAMPLE
    } phase_e;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
        logic [OSR_W-1:0] osr;
        logic [AVG_W-1:0] avg_log;
    } cfg_t;
endpackage

// File: rtl/thermo_regfile.sv
module thermo_regfile
    import thermo_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [CODE_W-1:0] stat_code,
    input  logic              stat_valid,
    output logic [CTL_W-1:0]  rd_data,
    output cfg_t              cfg
);
    typedef struct packed {
        logic [CTL_W-1:0] ctla;
        logic [CTL_W-1:0] ctlb;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0]       mode;
    logic [CTL_W-1:0] stat_word;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTLA: r_d.ctla = wr_data;
                ADDR_CTLB: r_d.ctlb = wr_data;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mode        = r_q.ctla[MODE_LSB +: 2];
        cfg.run     = r_q.ctla[BIT_START] & r_q.ctla[BIT_EN] & ~r_q.ctla[BIT_RST];
        cfg.sel     = (mode == MODE_EXT) ?
                      SEL_W'(r_q.ctla[CH_LSB +: CH_W]) + SEL_W'(1) : '0;
        cfg.osr     = r_q.ctla[OSR_LSB +: OSR_W];
        cfg.avg_log = r_q.ctla[BIT_BYP] ? '0 : r_q.ctlb[AVG_W-1:0];
    end

    always_comb begin
        stat_word                = '0;
        stat_word[CODE_W-1:0]    = stat_code;
        stat_word[VALID_BIT]     = stat_valid;
        case (addr)
            ADDR_CTLA: rd_data = r_q.ctla;
            ADDR_CTLB: rd_data = r_q.ctlb;
            ADDR_STAT: rd_data = stat_word;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/thermo_seq.sv
module thermo_seq
    import thermo_pkg::*;
#(
    parameter int SETTLE_CYC  = 750000,
    parameter int SAMPLE_BASE = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    output logic strobe,
    output logic flush
);
    localparam int MAX_PERIOD = SAMPLE_BASE << ((1 << OSR_W) - 1);
    localparam int MAX_CNT    = (SETTLE_CYC > MAX_PERIOD) ? SETTLE_CYC : MAX_PERIOD;
    localparam int CNT_W      = $clog2(MAX_CNT + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] src;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] period_m1;
    logic             src_moved;

    always_comb begin
        period_m1 = (CNT_W'(SAMPLE_BASE) << cfg.osr) - CNT_W'(1);
        src_moved = (cfg.sel != s_q.src);
        s_d       = s_q;
        flush     = 1'b0;
        strobe    = cfg.run && !src_moved && (s_q.phase == PH_SAMPLE) && (s_q.cnt == '0);

        if (!cfg.run) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            flush     = 1'b1;
        end else if (s_q.phase == PH_IDLE || src_moved) begin
            s_d.phase = PH_SETTLE;
            s_d.cnt   = CNT_W'(SETTLE_CYC - 1);
            s_d.src   = cfg.sel;
            flush     = 1'b1;
        end else if (s_q.cnt == '0) begin
            s_d.phase = PH_SAMPLE;
            s_d.cnt   = period_m1;
        end else begin
            s_d.cnt   = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, cnt: '0, src: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/thermo_avg.sv
module thermo_avg
    import thermo_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    input  logic [AVG_W-1:0]  avg_log,
    output logic [CODE_W-1:0] result,
    output logic              valid
);
    localparam int MAX_LOG = (1 << AVG_W) - 1;
    localparam int ACC_W   = CODE_W + MAX_LOG;
    localparam int NCNT_W  = MAX_LOG + 2;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [NCNT_W-1:0] n;
        logic [CODE_W-1:0] res;
        logic              vld;
    } avg_t;

    avg_t a_d, a_q;
    logic [ACC_W-1:0]  acc_nx;
    logic [NCNT_W-1:0] n_nx;
    logic [NCNT_W-1:0] target;

    always_comb begin
        a_d    = a_q;
        acc_nx = a_q.acc + ACC_W'(code);
        n_nx   = a_q.n + NCNT_W'(1);
        target = NCNT_W'(1) << avg_log;
        if (flush) begin
            a_d.acc = '0;
            a_d.n   = '0;
            a_d.vld = 1'b0;
        end else if (take) begin
            if (n_nx >= target) begin
                a_d.res = CODE_W'(acc_nx >> avg_log);
                a_d.vld = 1'b1;
                a_d.acc = '0;
                a_d.n   = '0;
            end else begin
                a_d.acc = acc_nx;
                a_d.n   = n_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign result = a_q.res;
    assign valid  = a_q.vld;
endmodule

// File: rtl/thermo_sensor_ctrl.sv
module thermo_sensor_ctrl
    import thermo_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int SETTLE_CYC  = 750000,
    parameter int SAMPLE_BASE = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [CODE_W-1:0] raw_code,
    output logic              smp_strobe,
    output logic [4:0]        mux_sel
);
    cfg_t              cfg;
    logic              flush;
    logic              strobe_w;
    logic [CODE_W-1:0] res_w;
    logic              valid_w;
    logic              run_w;

    thermo_regfile #(.CODE_W(CODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .stat_code  (res_w),
        .stat_valid (valid_w),
        .rd_data    (rd_data),
        .cfg        (cfg)
    );

    thermo_seq #(.SETTLE_CYC(SETTLE_CYC), .SAMPLE_BASE(SAMPLE_BASE)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .strobe (strobe_w),
        .flush  (flush)
    );

    thermo_avg #(.CODE_W(CODE_W)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .take    (strobe_w),
        .code    (raw_code),
        .avg_log (cfg.avg_log),
        .result  (res_w),
        .valid   (valid_w)
    );

    assign run_w      = cfg.run;
    assign smp_strobe = strobe_w;
    assign mux_sel    = cfg.sel;
endmodule

// File: rtl/thermo_sensor_ctrl_chk.sv
module thermo_sensor_ctrl_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_w,
    input logic [4:0]        mux_sel,
    input logic              smp_strobe,
    input logic              valid_w,
    input logic [CODE_W-1:0] res_w
);
    a_r3_no_strobe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> !smp_strobe);

    a_r10_stop_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !valid_w);

    a_r6_switch_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && $past(run_w) && (mux_sel != $past(mux_sel))) |=> !valid_w);

    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_w) |-> $past(smp_strobe));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_w && !$past(smp_strobe)) |-> $stable(res_w));
endmodule

bind thermo_sensor_ctrl thermo_sensor_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_w      (run_w),
    .mux_sel    (mux_sel),
    .smp_strobe (smp_strobe),
    .valid_w    (valid_w),
    .res_w      (res_w)
);

// File: tb/tb_thermo_sensor_ctrl.sv
module tb_thermo_sensor_ctrl;
    localparam int S = 20;
    localparam int B = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  addr = 2'd2;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [9:0]  raw_code;
    logic        smp_strobe;
    logic [4:0]  mux_sel;

    int errs = 0;
    int checks = 0;
    int idx = 0;
    logic clr_idx = 0;
    bit done = 0;

    always #10 clk = ~clk;

    thermo_sensor_ctrl #(.CODE_W(10), .SETTLE_CYC(S), .SAMPLE_BASE(B)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .raw_code(raw_code), .smp_strobe(smp_strobe), .mux_sel(mux_sel)
    );

    function automatic int base_of(input int sel);
        return 100 + 37 * sel;
    endfunction

    // probe stub: k-th sample of a run returns base + 2k
    assign raw_code = 10'(base_of(int'(mux_sel)) + 2 * (idx + 1));
    always @(posedge clk) begin
        if (clr_idx) idx <= 0;
        else if (smp_strobe) idx <= idx + 1;
    end

    function automatic logic [31:0] ctla(input bit st, input bit rs, input bit en, input bit byp,
                                         input int osr, input int mode, input int ch);
        logic [31:0] v = '0;
        v[0] = st; v[1] = rs; v[2] = en; v[6] = byp;
        v[25:24] = 2'(osr); v[31:30] = 2'(mode); v[16:13] = 4'(ch);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk); wr_en = 0; addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rd_data; addr = 2'd2;
    endtask

    // write control A and follow the run until valid rises
    task automatic run_meas(input logic [31:0] c, input int exp_code, input int exp_lat,
                            input int exp_first, input string req);
        int cyc = 0;
        int first = -1;
        wr(2'd0, c);
        clr_idx = 1;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk); clr_idx = 0;
            if (cyc == 1) chk(rd_data[16] == 0, "R6", "valid low after start/switch", rd_data[16], 0);
            if (smp_strobe && first < 0) first = cyc;
        end while (!rd_data[16] && cyc < 3000);
        chk(first == exp_first, "R5", {req, " first strobe cycle"}, first, exp_first);
        chk(cyc == exp_lat, "R9", {req, " valid latency"}, cyc, exp_lat);
        chk(int'(rd_data[9:0]) == exp_code, "R8", {req, " result"}, rd_data[9:0], exp_code);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (smp_strobe) seen++;
        end
        chk(seen == 0, req, "strobes while not running", seen, 0);
        chk(rd_data[16] == 0, req, "valid while not running", rd_data[16], 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v == 0, "R1", "control A at reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1", "control B at reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1", "status at reset", v, 0);
        chk(smp_strobe == 0, "R1", "strobe at reset", smp_strobe, 0);
        chk(mux_sel == 0, "R1", "mux_sel at reset", mux_sel, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'hC0A5_E0F0);
        rd(2'd0, v); chk(v == 32'hC0A5_E0F0, "R2", "control A readback", v, 32'hC0A5_E0F0);
        wr(2'd1, 32'h0000_0005);
        rd(2'd1, v); chk(v == 32'h5, "R2", "control B readback", v, 5);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk(v == 0, "R2", "status ignores write", v, 0);
        wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    endtask

    task automatic t_internal();
        // mode 0 with a nonzero channel field: internal probe, one sample
        run_meas(ctla(1, 0, 1, 0, 0, 0, 5), base_of(0) + 2, S + B + 1, S + B, "internal");
        chk(mux_sel == 0, "R4", "internal ignores channel field", mux_sel, 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_external();
        wr(2'd1, 32'd1);
        run_meas(ctla(1, 0, 1, 0, 1, 2, 2), base_of(3) + 3, S + 2 * 2 * B + 1, S + 2 * B, "ext avg2");
        chk(mux_sel == 3, "R4", "external index plus one", mux_sel, 3);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_slow();
        wr(2'd1, 32'd3);
        run_meas(ctla(1, 0, 1, 0, 3, 2, 0), base_of(1) + 9, S + 8 * 8 * B + 1, S + 8 * B, "R7 osr3 avg8");
        wr(2'd0, 32'h0);
    endtask

    task automatic t_bypass_and_switch();
        wr(2'd1, 32'd3);
        run_meas(ctla(1, 0, 1, 1, 0, 2, 4), base_of(5) + 2, S + B + 1, S + B, "bypass");
        // switch probe while running: valid drops and settle restarts
        run_meas(ctla(1, 0, 1, 1, 0, 0, 4), base_of(0) + 2, S + B + 1, S + B, "R6 switch");
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(2'd0, ctla(0, 0, 1, 1, 0, 0, 4));
        rd(2'd2, v); chk(v[16] == 0, "R10", "valid after clearing start", v[16], 0);
        quiet(40, "R3");
        wr(2'd0, ctla(1, 1, 1, 1, 0, 0, 0));
        quiet(40, "R3");
        wr(2'd0, ctla(1, 0, 0, 1, 0, 0, 0));
        quiet(40, "R3");
    endtask

    task automatic t_flush();
        int seen = 0;
        wr(2'd1, 32'd2);
        wr(2'd0, ctla(1, 0, 1, 0, 0, 0, 0));
        while (seen < 2) begin
            @(negedge clk);
            if (smp_strobe) seen++;
        end
        wr(2'd0, 32'h0);
        run_meas(ctla(1, 0, 1, 0, 0, 0, 0), base_of(0) + 5, S + 4 * B + 1, S + B, "R10 flush restart");
        wr(2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_internal();
        t_external();
        t_slow();
        t_bypass_and_switch();
        t_stop();
        t_flush();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule